// File: doc/BRIEF.md
# Four-Level Interrupt Priority Controller

This block decides which of up to twelve interrupt sources a CPU core services next. Each source has a request flag, an enable bit and two priority bits. One priority bit comes from a high priority word and one from a low priority word, and together they give a level from 0 to 3. A global enable gates every source. At each instruction boundary the controller picks one winner among the sources that are allowed to request. It then raises an interrupt request toward the core and presents the winner's index and its vector address. These stay fixed until the core acknowledges that it has taken the vector.

The controller keeps a record of nested handlers as a four-bit in-service set, with one bit per level. Taking a vector marks the winner's level as active. A return from a handler clears the highest active level. A new request is allowed only when its level is strictly above every active level.

Two source slots are fed by external pin samplers instead of flag inputs. Each sampler samples its active-low pin once per machine cycle, which is two clocks. It works in one of two modes. In edge mode it latches a flag on a high-to-low pair of samples. In level mode it follows the sampled pin directly.

Top module: `intprio_ctrl`

## Requirements
- R1: The level of source i is {prio_hi[i], prio_lo[i]}, with prio_hi as the MSB. Level 3 is the highest and level 0 the lowest.
- R2: A source may win only when its request, its src_en bit and glb_en are all 1.
- R3: When eligible requests of different levels are present at an instruction boundary, the one with the higher level wins.
- R4: Among eligible requests of equal level, the lowest source index wins.
- R5: A request is eligible only if its level is strictly greater than every level set in in_service. Requests at an equal or lower level wait.
- R6: While bit 3 of in_service is set, no new interrupt is raised.
- R7: The winner is captured on an insn_bound cycle when no request is pending. irq, irq_idx and irq_vec then stay unchanged until vec_ack, and irq_vec = VEC_BASE + irq_idx*VEC_STRIDE (0x0003 + 8*idx by default).
- R8: vec_ack sets the in_service bit of the taken level and drops irq. reti clears the highest set in_service bit.
- R9: In edge mode (ext_edge=1), an external flag is set when one machine-cycle sample of the pin is high and the next is low. The flag is cleared when its vector is acknowledged, and a pin that simply stays low does not set it again. External pin 0 feeds source 0 and pin 1 feeds source 2, and src_flag bits 0 and 2 are ignored.
- R10: In level mode (ext_edge=0), the external request equals the inverted sampled pin. It requests again after the handler returns if the pin is still low, and it stops once the pin is high.
- R11: After reset, irq is 0, in_service is 0 and both external pins are taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_flag | input | 12 | Per-source request flags (bits 0 and 2 unused) |
| src_en | input | 12 | Per-source enables |
| glb_en | input | 1 | Global interrupt enable |
| prio_hi | input | 12 | Priority MSB per source |
| prio_lo | input | 12 | Priority LSB per source |
| ext_pin | input | 2 | Active-low external interrupt pins |
| ext_edge | input | 2 | Per-pin mode: 1 edge, 0 level |
| insn_bound | input | 1 | Instruction boundary strobe |
| vec_ack | input | 1 | Core has taken the vector |
| reti | input | 1 | Return from handler |
| irq | output | 1 | Interrupt request to core |
| irq_idx | output | 4 | Index of the captured winner |
| irq_vec | output | 16 | Vector address of the captured winner |
| in_service | output | 4 | Active handler levels, one bit per level |

## Verification
The assertions assume that the core pulses vec_ack only while irq is high, and that vec_ack and reti never occur in the same cycle. Under those conditions the in-service set changes by exactly one bit per handshake. The bench issues each handshake as a single-cycle pulse from its own tasks, with a gap of at least one cycle between handshakes. It holds every external pin level for four clocks, which covers at least two machine-cycle samples.

// File: rtl/intprio_pkg.sv
package intprio_pkg;
  typedef logic [1:0] lvl_t;

  // clear the highest set bit of the in-service set
  function automatic logic [3:0] drop_top(input logic [3:0] s);
    logic [3:0] r;
    logic done;
    r = s;
    done = 1'b0;
    for (int k = 3; k >= 0; k--) begin
      if (!done && s[k]) begin
        r[k] = 1'b0;
        done = 1'b1;
      end
    end
    return r;
  endfunction

  // a level may interrupt only if no active level is at or above it
  function automatic logic may_preempt(input logic [3:0] s, input lvl_t l);
    return (s >> l) == 4'd0;
  endfunction

  function automatic int unsigned vec_of(input int unsigned base, input int unsigned stride,
                                         input int unsigned idx);
    return base + idx * stride;
  endfunction
endpackage

// File: rtl/ext_sampler.sv
module ext_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic samp_q, flag_q, fall;

  assign fall = tick && samp_q && !pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (tick) samp_q <= pin;
      if (fall && edge_mode) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign req = edge_mode ? flag_q : !samp_q;

  // R9: a sampled high-to-low pair latches the flag
  p_edge_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && edge_mode) |=> flag_q);
  // R9: acknowledge without a fresh fall clears the flag
  p_ack_clears_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(fall && edge_mode)) |=> !flag_q);
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NSRC = 12,
  localparam int IW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  input  logic            glb,
  input  logic [NSRC-1:0] hi,
  input  logic [NSRC-1:0] lo,
  input  logic [3:0]      isv,
  output logic            any,
  output logic [IW-1:0]   idx,
  output intprio_pkg::lvl_t lvl
);
  import intprio_pkg::*;

  always_comb begin
    any = 1'b0;
    idx = '0;
    lvl = 2'd0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && en[i] && glb && may_preempt(isv, {hi[i], lo[i]})) begin
        // strict compare keeps the lowest index on a tie
        if (!any || {hi[i], lo[i]} > lvl) begin
          any = 1'b1;
          idx = IW'(i);
          lvl = {hi[i], lo[i]};
        end
      end
    end
  end
endmodule

// File: rtl/isr_stack.sv
module isr_stack (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  intprio_pkg::lvl_t push_lvl,
  input  logic pop,
  output logic [3:0] isv
);
  import intprio_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isv <= 4'd0;
    else if (pop) isv <= drop_top(isv);
    else if (push) isv[push_lvl] <= 1'b1;
  end

  // R8: taking a vector marks its level active
  p_push_marks_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> isv[$past(push_lvl)]);
  // R8: a return removes exactly one active level
  p_pop_drops_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && isv != 4'd0) |=> $countones(isv) == $countones($past(isv)) - 1);
endmodule

// File: rtl/intprio_ctrl.sv
module intprio_ctrl #(
  parameter int NSRC       = 12,
  parameter int VW         = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int EXT0_IDX   = 0,
  parameter int EXT1_IDX   = 2,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_flag,
  input  logic [NSRC-1:0] src_en,
  input  logic            glb_en,
  input  logic [NSRC-1:0] prio_hi,
  input  logic [NSRC-1:0] prio_lo,
  input  logic [1:0]      ext_pin,
  input  logic [1:0]      ext_edge,
  input  logic            insn_bound,
  input  logic            vec_ack,
  input  logic            reti,
  output logic            irq,
  output logic [IW-1:0]   irq_idx,
  output logic [VW-1:0]   irq_vec,
  output logic [3:0]      in_service
);
  import intprio_pkg::*;

  logic phase_q;
  logic [1:0] ext_req;
  logic [NSRC-1:0] req_all;
  logic win_any, capture, taken;
  logic [IW-1:0] win_idx;
  lvl_t win_lvl, hold_lvl;

  // machine cycle = two clocks; sample on the second
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else phase_q <= !phase_q;
  end

  assign taken = vec_ack && irq;

  for (genvar g = 0; g < 2; g++) begin : g_ext
    localparam int XI = (g == 0) ? EXT0_IDX : EXT1_IDX;
    ext_sampler u_smp (
      .clk(clk), .rst_n(rst_n), .tick(phase_q), .pin(ext_pin[g]),
      .edge_mode(ext_edge[g]), .clr(taken && irq_idx == IW'(XI)), .req(ext_req[g])
    );
  end

  always_comb begin
    req_all = src_flag;
    req_all[EXT0_IDX] = ext_req[0];
    req_all[EXT1_IDX] = ext_req[1];
  end

  prio_pick #(.NSRC(NSRC)) u_pick (
    .req(req_all), .en(src_en), .glb(glb_en), .hi(prio_hi), .lo(prio_lo),
    .isv(in_service), .any(win_any), .idx(win_idx), .lvl(win_lvl)
  );

  assign capture = insn_bound && !irq && win_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      irq_idx  <= '0;
      hold_lvl <= 2'd0;
    end else if (capture) begin
      irq      <= 1'b1;
      irq_idx  <= win_idx;
      hold_lvl <= win_lvl;
    end else if (taken) begin
      irq <= 1'b0;
    end
  end

  assign irq_vec = VW'(vec_of(VEC_BASE, VEC_STRIDE, 32'(irq_idx)));

  isr_stack u_stack (
    .clk(clk), .rst_n(rst_n), .push(taken), .push_lvl(hold_lvl),
    .pop(reti), .isv(in_service)
  );

  // R7: captured winner is frozen until acknowledged
  p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !vec_ack) |=> (irq && $stable(irq_idx)));
  // R5: a new request is strictly above every active level
  p_strict_preempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> may_preempt(in_service, hold_lvl));
  // R6: nothing is raised while the top level is active
  p_top_level_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_service[3] |-> !$rose(irq));
  // R2: no request is raised without the global enable
  p_global_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(glb_en));
endmodule

// File: tb/intprio_ctrl_tb_top.sv
module intprio_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] src_flag = '0, src_en = '0, prio_hi = '0, prio_lo = '0;
  logic glb_en = 1'b0;
  logic [1:0] ext_pin = 2'b11, ext_edge = 2'b00;
  logic insn_bound = 1'b0, vec_ack = 1'b0, reti = 1'b0;
  logic irq;
  logic [3:0] irq_idx;
  logic [15:0] irq_vec;
  logic [3:0] in_service;
  int checks = 0;
  int fails = 0;

  always #2 clk = !clk;

  intprio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en), .glb_en(glb_en),
    .prio_hi(prio_hi), .prio_lo(prio_lo), .ext_pin(ext_pin), .ext_edge(ext_edge),
    .insn_bound(insn_bound), .vec_ack(vec_ack), .reti(reti),
    .irq(irq), .irq_idx(irq_idx), .irq_vec(irq_vec), .in_service(in_service)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic boundary();
    insn_bound = 1'b1; step(1); insn_bound = 1'b0;
  endtask
  task automatic take();
    vec_ack = 1'b1; step(1); vec_ack = 1'b0; step(1);
  endtask
  task automatic ret();
    reti = 1'b1; step(1); reti = 1'b0; step(1);
  endtask
  task automatic set_lvl(input int i, input int l);
    prio_hi[i] = l[1]; prio_lo[i] = l[0];
  endtask
  function automatic int vec(input int i);
    return 3 + 8 * i;
  endfunction

  task automatic t_reset();   // R11
    chk("R11 irq after reset", irq, 0);
    chk("R11 in_service after reset", in_service, 0);
  endtask

  task automatic t_gate();    // R2, R7, R8
    src_flag = 12'h020; set_lvl(5, 0); glb_en = 1'b1;
    boundary(); chk("R2 source enable off", irq, 0);
    src_en = 12'h020; glb_en = 1'b0;
    boundary(); chk("R2 global enable off", irq, 0);
    glb_en = 1'b1;
    boundary(); chk("R2 both enables", irq, 1);
    chk("R7 index", irq_idx, 5);
    chk("R7 vector", irq_vec, vec(5));
    take(); chk("R8 ack drops irq", irq, 0);
    chk("R8 ack marks level 0", in_service, 4'b0001);
    src_flag = '0; ret(); chk("R8 return clears", in_service, 0);
  endtask

  task automatic t_levels();  // R1, R3
    src_en = 12'h088; src_flag = 12'h088;
    set_lvl(3, 1); set_lvl(7, 2);
    boundary(); chk("R1 R3 level 2 beats level 1", irq_idx, 7);
    take(); chk("R1 hi bit gives level 2", in_service, 4'b0100);
    src_flag = 12'h000; ret();
    src_flag = 12'h088; set_lvl(3, 3);
    boundary(); chk("R3 level 3 beats level 2", irq_idx, 3);
    take(); chk("R1 both bits give level 3", in_service, 4'b1000);
    src_flag = '0; ret();
  endtask

  task automatic t_tie();     // R4
    src_en = 12'h210; src_flag = 12'h210; set_lvl(4, 2); set_lvl(9, 2);
    boundary(); chk("R4 lower index wins tie", irq_idx, 4);
    take(); src_flag = '0; ret();
  endtask

  task automatic t_preempt(); // R5, R8
    src_en = 12'h540; set_lvl(6, 1); set_lvl(8, 1); set_lvl(10, 2);
    src_flag = 12'h040; boundary(); take(); src_flag = 12'h100;
    chk("R5 level 1 active", in_service, 4'b0010);
    boundary(); chk("R5 equal level waits", irq, 0);
    src_flag = 12'h500;
    boundary(); chk("R5 higher level preempts", irq_idx, 10);
    take(); chk("R8 nested set", in_service, 4'b0110);
    src_flag = '0;
    ret(); chk("R8 return clears highest", in_service, 4'b0010);
    ret(); chk("R8 second return", in_service, 0);
  endtask

  task automatic t_top();     // R6, R7
    src_en = 12'h822; set_lvl(1, 3); set_lvl(11, 3); set_lvl(5, 2);
    src_flag = 12'h020; boundary();
    chk("R7 captured index", irq_idx, 5);
    src_flag = 12'h822; boundary();
    chk("R7 index held until ack", irq_idx, 5);
    chk("R7 vector held", irq_vec, vec(5));
    take(); src_flag = 12'h002; boundary(); take();
    chk("R6 top level active", in_service, 4'b1100);
    src_flag = 12'h822; boundary();
    chk("R6 no request under top level", irq, 0);
    src_flag = '0; ret(); ret();
  endtask

  task automatic t_edge();    // R9
    src_en = 12'h005; set_lvl(0, 1); ext_edge = 2'b01; src_flag = 12'h005;
    boundary(); chk("R9 src_flag ignored on external slot", irq, 0);
    ext_pin[0] = 1'b0; step(4);
    boundary(); chk("R9 falling edge requests", irq, 1);
    chk("R9 external pin 0 is source 0", irq_idx, 0);
    take(); ret();
    boundary(); chk("R9 steady low does not re-request", irq, 0);
    ext_pin[0] = 1'b1; step(4); src_flag = '0;
  endtask

  task automatic t_level();   // R10
    src_en = 12'h004; set_lvl(2, 2); ext_edge = 2'b00;
    ext_pin[1] = 1'b0; step(4);
    boundary(); chk("R10 low level requests", irq_idx, 2);
    chk("R10 vector", irq_vec, vec(2));
    take(); ret();
    boundary(); chk("R10 still low requests again", irq, 1);
    take(); ext_pin[1] = 1'b1; step(4); ret();
    boundary(); chk("R10 high level stops", irq, 0);
  endtask

  initial begin
    step(2); rst_n = 1'b1; step(1);
    t_reset();
    t_gate();
    t_levels();
    t_tie();
    t_preempt();
    t_top();
    t_edge();
    t_level();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule